// File: doc/BRIEF.md
# Fast Page Mode DRAM Controller

This block sits between a single-bit request stream and an asynchronous 4M x 1 DRAM whose row and column addresses share one 11-bit pin group. Each request carries a 22-bit word address, a direction flag and one write bit. The controller opens the row and strobes the column. For a write it drives the data line, and for a read it samples the device output. It then leaves the row open, so that a following request to the same row costs only a column strobe.

Refresh uses the variant in which the column strobe falls first, so the device's internal counter selects the row. A free-running interval timer marks one refresh as owed in each slot. An owed refresh is served at the next gap between accesses, and it closes any open page first. After reset the controller holds every strobe inactive for a power-up pause. It then issues a burst of refreshes before it accepts the first request. Every timing limit is a parameter counted in system clock cycles.

Request port rules: the requester raises `req_valid` and holds the address, direction and write bit steady until `req_ready` is seen high. `req_ready` is high for exactly one cycle per completed access. That cycle is the handshake, and for a read `rsp_rdata` is valid in it. The controller may stall a request for as long as it needs (row close, precharge, refresh or power-up). The requester may drop `req_valid` only after the handshake cycle.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: The row is bits 21..11 of `req_addr` and the column is bits 10..0. The row is on `dram_a` when `dram_ras_n` falls, and the column is on `dram_a` when `dram_cas_n` falls.
- R2: No strobe falls before INIT_CYC cycles after reset. At least INIT_REFS refresh cycles complete before the first `req_ready`, and `req_ready` stays low until then.
- R3: A refresh drops `dram_cas_n` while `dram_ras_n` is still high, and `dram_we_n` is high when `dram_ras_n` falls.
- R4: After initialisation, two successive refreshes are never more than REF_INTERVAL+16 cycles apart. An owed refresh takes priority over a waiting request, and the interval timer never expires while a refresh is still owed.
- R5: `dram_ras_n` stays high for at least T_RP cycles before each fall and stays low for at least T_RAS cycles. A column strobe comes at least T_RCD cycles after the row strobe.
- R6: A request to the row that is already open is served by a column strobe alone, with no new row activation.
- R7: A request to a different row closes the page (row strobe high, precharge) and activates the new row once.
- R8: For a write, `dram_we_n` is low and `dram_di` carries the data before `dram_cas_n` falls, and both are unchanged at the fall. For a read, `dram_we_n` stays high.
- R9: Read data is taken from `dram_do` after `dram_cas_n` has been low for T_CAS cycles, and a read returns the bit last written to that address (0 if never written).
- R10: `req_ready` is high for one cycle per access and never two cycles in a row. It is high only while `req_valid` is high.
- R11: `dram_ras_n` is never held low for more than PAGE_MAX cycles. An idle open page is closed by that limit or by refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | One-cycle access-complete handshake |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Word address, row in upper 11 bits |
| req_wdata | input | 1 | Write bit |
| rsp_rdata | output | 1 | Read bit, valid while `req_ready` is high |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_a | output | 11 | Multiplexed row/column address |
| dram_di | output | 1 | Data to device |
| dram_do | input | 1 | Data from device |

## Verification
Assertions check on every cycle the strobe ordering of a refresh, the minimum precharge before each row strobe, and that write enable and data are steady at the column strobe. They also check the single-cycle ready pulse, the page-time ceiling, and that no refresh slot expires while one is still owed. Only the bench scenarios can show that data written to the device model reads back and that the address halves land on the right strobes. The same holds for page hits avoiding a new activation, row misses activating exactly once, the refresh spacing over long runs of mixed traffic, and the count of power-up refreshes before the first access.

// File: rtl/dram_ctrl_pkg.sv
package dram_ctrl_pkg;
  typedef enum logic [3:0] {
    ST_PWRUP,
    ST_RF_CAS,
    ST_RF_RAS,
    ST_PRE,
    ST_IDLE,
    ST_ROW,
    ST_COLS,
    ST_CAS,
    ST_DONE,
    ST_OPEN
  } ctl_st_e;
endpackage

// File: rtl/dram_step_cnt.sv
module dram_step_cnt #(
  parameter int W       = 8,
  parameter int RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= W'(RST_VAL);
    else if (load)   cnt <= load_val;
    else if (!zero)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/dram_rfsh_timer.sv
module dram_rfsh_timer #(
  parameter int INTERVAL = 780
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic served,
  output logic owed
);
  localparam int TW = $clog2(INTERVAL + 1);
  logic [TW-1:0] tcnt;
  logic          tick;

  assign tick = en && (tcnt == TW'(INTERVAL - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tcnt <= '0;
      owed <= 1'b0;
    end else begin
      if (!en)       tcnt <= '0;
      else if (tick) tcnt <= '0;
      else           tcnt <= tcnt + 1'b1;
      if (tick)        owed <= 1'b1;
      else if (served) owed <= 1'b0;
    end
  end

  // R4
  owed_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> !owed);
endmodule

// File: rtl/dram_ras_watch.sv
module dram_ras_watch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ras_n,
  output logic [W-1:0] hi_cnt,
  output logic [W-1:0] lo_cnt
);
  localparam logic [W-1:0] SAT = '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_cnt <= '0;
      lo_cnt <= '0;
    end else if (ras_n) begin
      lo_cnt <= '0;
      if (hi_cnt != SAT) hi_cnt <= hi_cnt + 1'b1;
    end else begin
      hi_cnt <= '0;
      if (lo_cnt != SAT) lo_cnt <= lo_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl
  import dram_ctrl_pkg::*;
#(
  parameter int ROW_W        = 11,
  parameter int COL_W        = 11,
  parameter int INIT_CYC     = 10000,
  parameter int INIT_REFS    = 8,
  parameter int REF_INTERVAL = 780,
  parameter int PAGE_MAX     = 9000,
  parameter int T_RP         = 2,
  parameter int T_RAS        = 3,
  parameter int T_RCD        = 2,
  parameter int T_CAS        = 2,
  parameter int T_CSR        = 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_we,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic                   req_wdata,
  output logic                   rsp_rdata,
  output logic                   dram_ras_n,
  output logic                   dram_cas_n,
  output logic                   dram_we_n,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_a,
  output logic                   dram_di,
  input  logic                   dram_do
);
  localparam int ADDR_W     = ROW_W + COL_W;
  localparam int A_W        = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int CNT_W      = $clog2(INIT_CYC + 1);
  localparam int WATCH_W    = $clog2(PAGE_MAX + 2) + 1;
  localparam int PAGE_CLOSE = PAGE_MAX - (T_CAS + 4);
  localparam int REFN_W     = $clog2(INIT_REFS + 1);

  ctl_st_e st, nxt;
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic             zero;
  logic             owed, served, init_done;
  logic [REFN_W-1:0] init_left;
  logic [ROW_W-1:0]  open_row;
  logic [COL_W-1:0]  cur_col;
  logic              cur_we, cur_wd;
  logic [WATCH_W-1:0] hi_cnt, lo_cnt;
  logic              row_hit, page_old, take_req;

  dram_step_cnt #(.W(CNT_W), .RST_VAL(INIT_CYC - 1)) u_step (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val), .zero(zero)
  );

  dram_rfsh_timer #(.INTERVAL(REF_INTERVAL)) u_rfsh (
    .clk(clk), .rst_n(rst_n), .en(init_done), .served(served), .owed(owed)
  );

  dram_ras_watch #(.W(WATCH_W)) u_watch (
    .clk(clk), .rst_n(rst_n), .ras_n(dram_ras_n), .hi_cnt(hi_cnt), .lo_cnt(lo_cnt)
  );

  assign init_done = (init_left == '0);
  assign served    = (st == ST_RF_RAS) && zero && init_done;
  assign row_hit   = (req_addr[ADDR_W-1 -: ROW_W] == open_row);
  assign page_old  = (lo_cnt >= WATCH_W'(PAGE_CLOSE)) && (lo_cnt >= WATCH_W'(T_RAS));

  always_comb begin
    nxt      = st;
    load     = 1'b0;
    load_val = '0;
    take_req = 1'b0;
    case (st)
      ST_PWRUP: if (zero) begin
        nxt = ST_RF_CAS; load = 1'b1; load_val = CNT_W'(T_CSR - 1);
      end
      ST_RF_CAS: if (zero) begin
        nxt = ST_RF_RAS; load = 1'b1; load_val = CNT_W'(T_RAS - 1);
      end
      ST_RF_RAS: if (zero) begin
        nxt = ST_PRE; load = 1'b1; load_val = CNT_W'(T_RP - 1);
      end
      ST_PRE: if (zero) begin
        if (!init_done || owed) begin
          nxt = ST_RF_CAS; load = 1'b1; load_val = CNT_W'(T_CSR - 1);
        end else begin
          nxt = ST_IDLE;
        end
      end
      ST_IDLE: begin
        if (owed) begin
          nxt = ST_RF_CAS; load = 1'b1; load_val = CNT_W'(T_CSR - 1);
        end else if (req_valid) begin
          nxt = ST_ROW; load = 1'b1; load_val = CNT_W'(T_RCD - 1);
        end
      end
      ST_ROW: if (zero) begin
        nxt = ST_COLS; take_req = 1'b1;
      end
      ST_COLS: begin
        nxt = ST_CAS; load = 1'b1; load_val = CNT_W'(T_CAS - 1);
      end
      ST_CAS: if (zero) nxt = ST_DONE;
      ST_DONE: nxt = ST_OPEN;
      ST_OPEN: begin
        if (owed || page_old || (req_valid && !row_hit)) begin
          nxt = ST_PRE; load = 1'b1; load_val = CNT_W'(T_RP - 1);
        end else if (req_valid) begin
          nxt = ST_COLS; take_req = 1'b1;
        end
      end
      default: nxt = ST_PRE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_PWRUP;
      init_left <= REFN_W'(INIT_REFS);
      open_row  <= '0;
      cur_col   <= '0;
      cur_we    <= 1'b0;
      cur_wd    <= 1'b0;
      rsp_rdata <= 1'b0;
    end else begin
      st <= nxt;
      if (st == ST_RF_RAS && zero && !init_done) init_left <= init_left - 1'b1;
      if (st == ST_IDLE && nxt == ST_ROW) open_row <= req_addr[ADDR_W-1 -: ROW_W];
      if (take_req) begin
        cur_col <= req_addr[COL_W-1:0];
        cur_we  <= req_we;
        cur_wd  <= req_wdata;
      end
      if (st == ST_CAS && zero && !cur_we) rsp_rdata <= dram_do;
    end
  end

  assign dram_ras_n = !(st inside {ST_RF_RAS, ST_ROW, ST_COLS, ST_CAS, ST_DONE, ST_OPEN});
  assign dram_cas_n = !(st inside {ST_RF_CAS, ST_RF_RAS, ST_CAS});
  assign dram_we_n  = !((st inside {ST_COLS, ST_CAS}) && cur_we);
  assign dram_a     = (st == ST_ROW) ? A_W'(open_row) : A_W'(cur_col);
  assign dram_di    = cur_wd;
  assign req_ready  = (st == ST_DONE);

  // R3
  cbr_we_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dram_ras_n) && !dram_cas_n) |-> dram_we_n);
  // R5
  ras_precharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) |-> (hi_cnt >= WATCH_W'(T_RP)));
  // R8
  early_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dram_cas_n) && !dram_ras_n) |-> ($stable(dram_we_n) && $stable(dram_di)));
  // R10
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready);
  // R10
  ready_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> req_valid);
  // R2
  no_access_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> !req_ready);
  // R11
  page_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lo_cnt <= WATCH_W'(PAGE_MAX));
endmodule

// File: tb/sim_fpm_dram_ctrl.sv
module sim_fpm_dram_ctrl;
  localparam int INIT_CYC = 300;
  localparam int INIT_REFS = 8;
  localparam int REF_INTERVAL = 250;
  localparam int PAGE_MAX = 60;
  localparam int T_RP = 2, T_RAS = 3, T_RCD = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0, req_wdata = 1'b0;
  logic [21:0] req_addr = '0;
  logic req_ready, rsp_rdata, ras_n, cas_n, we_n, di;
  logic [10:0] a;
  logic dout = 1'b0;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int ras_hi = 0, ras_lo = 0, rcd = 0, refs = 0, opens = 0;
  int last_ref = -1, first_fall = -1, first_ready = -1, refs_at_ready = 0;
  int lat_row = 0, lat_col = 0;
  logic p_ras = 1'b1, p_cas = 1'b1;
  bit mem [int];
  bit shadow [int];

  always #10 clk = ~clk;

  fpm_dram_ctrl #(
    .INIT_CYC(INIT_CYC), .INIT_REFS(INIT_REFS), .REF_INTERVAL(REF_INTERVAL),
    .PAGE_MAX(PAGE_MAX), .T_RP(T_RP), .T_RAS(T_RAS), .T_RCD(T_RCD)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
    .dram_ras_n(ras_n), .dram_cas_n(cas_n), .dram_we_n(we_n), .dram_a(a),
    .dram_di(di), .dram_do(dout)
  );

  function automatic int row_of(logic [21:0] ad); return int'(ad[21:11]); endfunction
  function automatic int col_of(logic [21:0] ad); return int'(ad[10:0]); endfunction
  function automatic bit expect_bit(logic [21:0] ad);
    return shadow.exists(int'(ad)) ? shadow[int'(ad)] : 1'b0;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // device model and pin-level timing checks
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(1'b0, "watchdog", cyc, 150000);
      finish_run();
    end
    if (rst_n) begin
      if (p_ras && !ras_n) begin
        if (first_fall < 0) begin
          first_fall = cyc;
          chk(first_fall > INIT_CYC, "R2 pause before first strobe", first_fall, INIT_CYC);
        end
        chk(ras_hi >= T_RP, "R5 precharge", ras_hi, T_RP);
        if (!cas_n) begin
          chk(we_n, "R3 write enable high in refresh", int'(we_n), 1);
          refs++;
          if (last_ref >= 0 && refs > INIT_REFS)
            chk(cyc - last_ref <= REF_INTERVAL + 16, "R4 refresh spacing",
                cyc - last_ref, REF_INTERVAL + 16);
          last_ref = cyc;
        end else begin
          opens++;
          lat_row = int'(a);
        end
        rcd = 0;
      end
      if (!p_ras && ras_n) begin
        chk(ras_lo >= T_RAS, "R5 row strobe width", ras_lo, T_RAS);
        chk(ras_lo <= PAGE_MAX, "R11 page time", ras_lo, PAGE_MAX);
      end
      if (p_cas && !cas_n && !ras_n) begin
        chk(rcd >= T_RCD, "R5 row to column delay", rcd, T_RCD);
        lat_col = int'(a);
        if (!we_n) mem[(lat_row << 11) | lat_col] = di;
        else dout = mem.exists((lat_row << 11) | lat_col) ? mem[(lat_row << 11) | lat_col] : 1'b0;
      end
      ras_hi = ras_n ? ras_hi + 1 : 0;
      ras_lo = !ras_n ? ras_lo + 1 : 0;
      rcd++;
    end
    p_ras = ras_n;
    p_cas = cas_n;
  end

  task automatic access(input bit w, input logic [21:0] ad, input bit d);
    bit q;
    @(posedge clk); #1;
    req_valid = 1'b1; req_we = w; req_addr = ad; req_wdata = d;
    do @(negedge clk); while (!req_ready);
    q = rsp_rdata;
    if (first_ready < 0) begin first_ready = cyc; refs_at_ready = refs; end
    @(posedge clk); #1;
    req_valid = 1'b0;
    @(negedge clk);
    chk(!req_ready, "R10 ready one cycle", int'(req_ready), 0);
    chk(lat_row == row_of(ad), "R1 row half", lat_row, row_of(ad));
    chk(lat_col == col_of(ad), "R1 column half", lat_col, col_of(ad));
    if (w) shadow[int'(ad)] = d;
    else chk(q == expect_bit(ad), "R9 read data", int'(q), int'(expect_bit(ad)));
  endtask

  initial begin
    int o0, r0, idle_ready;
    void'($urandom(32'd20250611));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(ras_n && cas_n && we_n, "R2 strobes idle after reset", int'({ras_n, cas_n, we_n}), 7);
    chk(!req_ready, "R2 no ready after reset", int'(req_ready), 0);

    // first access waits out the power-up sequence
    access(1'b1, {11'd5, 11'd3}, 1'b1);
    chk(refs_at_ready >= INIT_REFS, "R2 refreshes before first access", refs_at_ready, INIT_REFS);
    chk(first_ready > INIT_CYC, "R2 first ready after pause", first_ready, INIT_CYC);

    // R8 and R9: write then read back both values
    access(1'b1, {11'd5, 11'd4}, 1'b0);
    access(1'b0, {11'd5, 11'd3}, 1'b0);
    access(1'b0, {11'd5, 11'd4}, 1'b0);

    // R6: page hit right after a fresh activation
    access(1'b1, {11'd9, 11'd0}, 1'b1);
    o0 = opens; r0 = refs;
    access(1'b0, {11'd9, 11'd0}, 1'b0);
    access(1'b1, {11'd9, 11'h7FF}, 1'b1);
    chk(opens - o0 == ((refs != r0) ? 1 : 0), "R6 page hit without activation",
        opens - o0, (refs != r0) ? 1 : 0);

    // R7: row miss activates exactly once
    o0 = opens;
    access(1'b0, {11'h7FF, 11'd1}, 1'b0);
    chk(opens - o0 == 1, "R7 row miss activation", opens - o0, 1);

    // R10 and R11: idle stretch, no ready, page closed
    idle_ready = 0;
    repeat (80) begin
      @(negedge clk);
      if (req_ready) idle_ready++;
    end
    chk(idle_ready == 0, "R10 no ready while idle", idle_ready, 0);
    chk(ras_n, "R11 idle page closed", int'(ras_n), 1);

    // constrained random mix over few rows and columns
    for (int i = 0; i < 400; i++) begin
      logic [10:0] rr, cc;
      case ($urandom % 4)
        0: rr = 11'd0;
        1: rr = 11'd5;
        2: rr = 11'd9;
        default: rr = 11'h7FF;
      endcase
      cc = (($urandom % 8) == 7) ? 11'h7FF : 11'($urandom % 8);
      access(1'($urandom % 2), {rr, cc}, 1'($urandom % 2));
    end

    // directed: long idle so several refreshes run back to back with no traffic
    repeat (600) @(posedge clk);
    access(1'b0, {11'd0, 11'd0}, 1'b0);
    chk(refs > INIT_REFS + 10, "R4 refreshes keep running", refs, INIT_REFS + 10);

    finish_run();
  end
endmodule